// File: doc/BRIEF.md
# Configuration-Space Enumeration Sequencer

This block takes over the discovery work that host software would normally do right after a serial link comes up. It waits for a link-active input, then visits bus numbers 1 to `MAX_BUS` in ascending order. On each bus it addresses only device 0, function 0, through a single configuration request port. On each bus it checks whether a function answers with a valid vendor ID. If one does, the block measures the memory window that BAR0 asks for, places that window at the next free aligned address, and turns on the I/O, memory and bus-master enables in the command register.

Requests go out on a valid/ready port. The block raises `req_valid` with the flag, address and data, and holds all of them unchanged until a cycle in which `req_ready` is high. That cycle is the handshake. A write is complete at its handshake and gets no response. A read is answered later by a one-cycle `rsp_valid` strobe that carries `rsp_rdata`. The block has at most one request outstanding. It ignores `rsp_valid` while no read is pending. If no answer arrives within `TIMEOUT` cycles of a read's handshake, the device on that bus is treated as absent.

After the last bus the block raises `scan_done` and freezes its results. The results are the count of configured devices, one presence bit per bus and one assigned 32-bit base per bus.

Top module: `cfg_enum_seq`

## Requirements
- R1: After reset and until `link_up` is first seen high, `req_valid` stays low, `scan_done` is 0 and `dev_count` is 0.
- R2: Every request address is `CFG_BASE | (bus << 20) | offset`. The offset is 0x000 for the vendor ID, 0x004 for the command register and 0x010 for BAR0. The bus field sits in bits 27:20, and buses are visited from 1 up to `MAX_BUS`.
- R3: Each bus starts with a read at offset 0x000. If bits 15:0 of the reply equal 0xFFFF, the function is absent and no further request goes to that bus.
- R4: For a present function, the block writes 0xFFFFFFFF to BAR0 and then reads BAR0. The window mask is the readback with bits 3:0 cleared, and the window size is the two's complement of that mask.
- R5: When the mask is nonzero, the block rounds the allocation pointer (which starts at `ALLOC_START`) up to a multiple of the window size. It writes that value to BAR0 as the base, and the pointer becomes base plus size.
- R6: When the mask is zero, the block writes no base, records base 0 for that bus and leaves the pointer unchanged. It still programs the command register.
- R7: The block reads the command register at offset 0x004 and writes back the value read with bits 0, 1 and 2 set.
- R8: If a read gets no `rsp_valid` within `TIMEOUT` cycles of its handshake, that bus counts as absent and scanning moves to the next bus.
- R9: A bus counts as configured only when its command write completes. At that point `dev_count` increments, presence bit bus-1 is set, and slot bus-1 of `base_flat` takes the assigned base.
- R10: After the last bus, `scan_done` rises and stays high, and the results no longer change. Changes on `link_up` after the scan has started have no effect.
- R11: While `req_valid` is high and `req_ready` is low, the request flag, address and data stay unchanged. A `rsp_valid` that arrives while no read is pending is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_up | input | 1 | Link active; starts the scan |
| req_valid | output | 1 | Configuration request valid |
| req_ready | input | 1 | Request accepted in this cycle |
| req_write | output | 1 | 1 = write, 0 = read |
| req_addr | output | 32 | Configuration address |
| req_wdata | output | 32 | Write data |
| rsp_valid | input | 1 | Read data strobe |
| rsp_rdata | input | 32 | Read data |
| scan_done | output | 1 | Scan finished, results frozen |
| dev_count | output | $clog2(MAX_BUS+1) | Number of configured devices |
| base_flat | output | MAX_BUS*32 | Assigned BAR0 base, slot bus-1 |
| present_mask | output | MAX_BUS | Configured flag, bit bus-1 |

## Verification
The hardest case to reach is the interaction of allocation-pointer alignment with windows of mixed sizes. A small window followed by a larger one has to produce a rounded-up base and a gap in the address map. The bench model gives the buses 16 MB, 4 KB, 32 MB and zero-sized BAR0 readbacks in that order, with attribute bits set in one of them, so that the rounding really happens. One bus never answers, which forces the timeout path. Random stalls on ready and on response latency exercise back-pressure at every step of the sequence.

// File: rtl/cfg_enum_pkg.sv
package cfg_enum_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ISSUE,
    PH_WAIT,
    PH_NEXT,
    PH_DONE
  } phase_t;

  typedef enum logic [2:0] {
    OP_VID,
    OP_BAR_ONES,
    OP_BAR_RD,
    OP_BAR_SET,
    OP_CMD_RD,
    OP_CMD_SET
  } op_t;

  localparam logic [11:0] OFF_ID   = 12'h000;
  localparam logic [11:0] OFF_CMD  = 12'h004;
  localparam logic [11:0] OFF_BAR0 = 12'h010;

  localparam logic [31:0] ENABLE_BITS = 32'h0000_0007;
  localparam logic [31:0] ATTR_BITS   = 32'h0000_000F;
  localparam logic [15:0] NO_VENDOR   = 16'hFFFF;

  function automatic logic [11:0] op_offset(op_t op);
    case (op)
      OP_VID:                  return OFF_ID;
      OP_CMD_RD, OP_CMD_SET:   return OFF_CMD;
      default:                 return OFF_BAR0;
    endcase
  endfunction

  function automatic logic op_is_write(op_t op);
    return (op == OP_BAR_ONES) || (op == OP_BAR_SET) || (op == OP_CMD_SET);
  endfunction

endpackage

// File: rtl/cfg_bar_calc.sv
module cfg_bar_calc #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] readback,
  input  logic [AW-1:0] alloc_ptr,
  output logic          win_valid,
  output logic [AW-1:0] win_mask,
  output logic [AW-1:0] win_size,
  output logic [AW-1:0] aligned_base,
  output logic [AW-1:0] next_ptr
);
  import cfg_enum_pkg::*;

  always_comb begin
    win_mask     = readback & ~AW'(ATTR_BITS);
    win_valid    = |win_mask;
    win_size     = ~win_mask + AW'(1);
    aligned_base = (alloc_ptr + ~win_mask) & win_mask;
    next_ptr     = aligned_base + win_size;
  end

endmodule

// File: rtl/cfg_rsp_timer.sv
module cfg_rsp_timer #(
  parameter int LIMIT = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  assign expired = run && (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt_q <= '0;
    else if (!run)     cnt_q <= '0;
    else if (!expired) cnt_q <= cnt_q + CW'(1);
  end

  assert_timer_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(LIMIT - 1));

endmodule

// File: rtl/cfg_result_bank.sv
module cfg_result_bank #(
  parameter int SLOTS  = 8,
  parameter int SLOT_W = 4,
  parameter int AW     = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [SLOT_W-1:0]   wr_slot,
  input  logic [AW-1:0]       wr_base,
  output logic [SLOTS*AW-1:0] base_flat,
  output logic [SLOTS-1:0]    present
);

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic [AW-1:0] base_q;
    logic          pres_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_q <= '0;
        pres_q <= 1'b0;
      end else if (wr_en && wr_slot == SLOT_W'(g)) begin
        base_q <= wr_base;
        pres_q <= 1'b1;
      end
    end
    assign base_flat[g*AW +: AW] = base_q;
    assign present[g]            = pres_q;
  end

  assert_slot_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_slot) < SLOTS));

  assert_slot_once_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(wr_slot) < SLOTS) |=> $past(present[wr_slot]) == 1'b0);

endmodule

// File: rtl/cfg_enum_seq.sv
module cfg_enum_seq #(
  parameter int          MAX_BUS     = 8,
  parameter int          TIMEOUT     = 256,
  parameter logic [31:0] CFG_BASE    = 32'hE000_0000,
  parameter logic [31:0] ALLOC_START = 32'h1000_0000,
  localparam int         BW          = $clog2(MAX_BUS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 link_up,
  output logic                 req_valid,
  input  logic                 req_ready,
  output logic                 req_write,
  output logic [31:0]          req_addr,
  output logic [31:0]          req_wdata,
  input  logic                 rsp_valid,
  input  logic [31:0]          rsp_rdata,
  output logic                 scan_done,
  output logic [BW-1:0]        dev_count,
  output logic [MAX_BUS*32-1:0] base_flat,
  output logic [MAX_BUS-1:0]   present_mask
);
  import cfg_enum_pkg::*;

  localparam int AW = 32;

  phase_t        ph_q;
  op_t           op_q;
  logic [BW-1:0] bus_q;
  logic [AW-1:0] ptr_q;
  logic [AW-1:0] base_q;
  logic [AW-1:0] cmd_q;
  logic [BW-1:0] count_q;
  logic          link_seen_q;

  logic          win_valid;
  logic [AW-1:0] win_mask, win_size, aligned_base, next_ptr;
  logic          timed_out;
  logic          handshake;
  logic          commit;

  cfg_bar_calc #(.AW(AW)) u_calc (
    .readback    (rsp_rdata),
    .alloc_ptr   (ptr_q),
    .win_valid   (win_valid),
    .win_mask    (win_mask),
    .win_size    (win_size),
    .aligned_base(aligned_base),
    .next_ptr    (next_ptr)
  );

  cfg_rsp_timer #(.LIMIT(TIMEOUT)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (ph_q == PH_WAIT),
    .expired(timed_out)
  );

  assign handshake = req_valid && req_ready;
  assign commit    = handshake && (op_q == OP_CMD_SET);

  cfg_result_bank #(.SLOTS(MAX_BUS), .SLOT_W(BW), .AW(AW)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (commit),
    .wr_slot  (bus_q - BW'(1)),
    .wr_base  (base_q),
    .base_flat(base_flat),
    .present  (present_mask)
  );

  assign req_valid = (ph_q == PH_ISSUE);
  assign req_write = op_is_write(op_q);
  assign req_addr  = CFG_BASE | (AW'(bus_q) << 20) | AW'(op_offset(op_q));
  assign scan_done = (ph_q == PH_DONE);
  assign dev_count = count_q;

  always_comb begin
    case (op_q)
      OP_BAR_ONES: req_wdata = '1;
      OP_BAR_SET:  req_wdata = base_q;
      OP_CMD_SET:  req_wdata = cmd_q;
      default:     req_wdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      op_q    <= OP_VID;
      bus_q   <= '0;
      ptr_q   <= ALLOC_START;
      base_q  <= '0;
      cmd_q   <= '0;
      count_q <= '0;
    end else begin
      case (ph_q)
        PH_IDLE: if (link_up) begin
          bus_q <= BW'(1);
          op_q  <= OP_VID;
          ph_q  <= PH_ISSUE;
        end
        PH_ISSUE: if (req_ready) begin
          if (!op_is_write(op_q)) ph_q <= PH_WAIT;
          else if (op_q == OP_BAR_ONES) op_q <= OP_BAR_RD;
          else if (op_q == OP_BAR_SET)  op_q <= OP_CMD_RD;
          else begin
            count_q <= count_q + BW'(1);
            ph_q    <= PH_NEXT;
          end
        end
        PH_WAIT: begin
          if (rsp_valid) begin
            ph_q <= PH_ISSUE;
            case (op_q)
              OP_VID: begin
                if (rsp_rdata[15:0] == NO_VENDOR) ph_q <= PH_NEXT;
                else op_q <= OP_BAR_ONES;
              end
              OP_BAR_RD: begin
                if (win_valid) begin
                  base_q <= aligned_base;
                  ptr_q  <= next_ptr;
                  op_q   <= OP_BAR_SET;
                end else begin
                  base_q <= '0;
                  op_q   <= OP_CMD_RD;
                end
              end
              default: begin
                cmd_q <= rsp_rdata | ENABLE_BITS;
                op_q  <= OP_CMD_SET;
              end
            endcase
          end else if (timed_out) begin
            ph_q <= PH_NEXT;
          end
        end
        PH_NEXT: begin
          if (bus_q == BW'(MAX_BUS)) ph_q <= PH_DONE;
          else begin
            bus_q <= bus_q + BW'(1);
            op_q  <= OP_VID;
            ph_q  <= PH_ISSUE;
          end
        end
        default: ph_q <= PH_DONE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       link_seen_q <= 1'b0;
    else if (link_up) link_seen_q <= 1'b1;
  end

  assert_quiet_before_link_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !link_seen_q |-> !req_valid);

  assert_bus_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_addr[27:20] != 8'd0) && (int'(req_addr[27:20]) <= MAX_BUS));

  assert_aligned_base_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_WAIT && op_q == OP_BAR_RD && rsp_valid && win_valid)
      |-> ((aligned_base & (win_size - 32'd1)) == 32'd0));

  assert_enable_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr[11:0] == OFF_CMD) |-> (req_wdata[2:0] == 3'b111));

  assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    int'(dev_count) <= MAX_BUS);

  assert_done_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |=> scan_done && $stable(dev_count) && $stable(base_flat) && $stable(present_mask));

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> req_valid && $stable(req_write) && $stable(req_addr)
                                  && $stable(req_wdata));

endmodule

// File: tb/tb_cfg_enum_seq.sv
module tb_cfg_enum_seq;
  localparam int          MAX_BUS = 6;
  localparam int          TMO     = 16;
  localparam logic [31:0] CBASE   = 32'hE000_0000;
  localparam logic [31:0] ASTART  = 32'h1000_0000;
  localparam int          BW      = $clog2(MAX_BUS + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic link_up = 1'b0;
  logic req_valid, req_write, req_ready = 1'b0;
  logic [31:0] req_addr, req_wdata;
  logic rsp_valid = 1'b0;
  logic [31:0] rsp_rdata = '0;
  logic scan_done;
  logic [BW-1:0] dev_count;
  logic [MAX_BUS*32-1:0] base_flat;
  logic [MAX_BUS-1:0] present_mask;

  always #4 clk = ~clk;

  cfg_enum_seq #(.MAX_BUS(MAX_BUS), .TIMEOUT(TMO), .CFG_BASE(CBASE), .ALLOC_START(ASTART)) dut (
    .clk(clk), .rst_n(rst_n), .link_up(link_up),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .scan_done(scan_done), .dev_count(dev_count),
    .base_flat(base_flat), .present_mask(present_mask)
  );

  int tests = 0;
  int fails = 0;

  // device model: kind 0 = present, 1 = vendor all ones, 2 = never answers
  int          kind   [1:MAX_BUS];
  logic [31:0] bar_rb [1:MAX_BUS];
  logic [15:0] cmd_in [1:MAX_BUS];

  logic [31:0] exp_base [1:MAX_BUS];
  logic [MAX_BUS-1:0] exp_present;
  int exp_count;

  logic [64:0] exp_q[$];
  string       tag_q[$];

  logic spur_req = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(input bit wr, input logic [31:0] a, input logic [31:0] d, input string tag);
    exp_q.push_back({wr, a, d});
    tag_q.push_back(tag);
  endtask

  task automatic build_expect();
    logic [31:0] ptr, m, sz, b, a;
    ptr = ASTART;
    exp_present = '0;
    exp_count = 0;
    for (int bus = 1; bus <= MAX_BUS; bus++) begin
      a = CBASE | (32'(bus) << 20);
      exp_base[bus] = '0;
      push(1'b0, a | 32'h000, '0, "R2/R3 vendor read");
      if (kind[bus] != 0) continue;
      push(1'b1, a | 32'h010, 32'hFFFF_FFFF, "R4 BAR0 ones write");
      push(1'b0, a | 32'h010, '0, "R4 BAR0 readback");
      m = bar_rb[bus] & ~32'hF;
      if (m != 0) begin
        sz = ~m + 32'd1;
        b  = (ptr + sz - 32'd1) & ~(sz - 32'd1);
        push(1'b1, a | 32'h010, b, "R5 BAR0 base write");
        ptr = b + sz;
      end else b = '0;
      push(1'b0, a | 32'h004, '0, "R7 command read");
      push(1'b1, a | 32'h004, {16'h0010, cmd_in[bus] | 16'h0007}, "R7 command write");
      exp_base[bus] = b;
      exp_present[bus-1] = 1'b1;
      exp_count++;
    end
  endtask

  // responder and monitor
  initial begin
    logic [7:0]  lfsr = 8'hA5;
    int          rsp_cnt = 0;
    logic [31:0] pend = '0;
    logic [64:0] e;
    string       t;
    int          bus;
    forever begin
      @(negedge clk);
      rsp_valid = 1'b0;
      if (spur_req) begin
        rsp_valid = 1'b1;
        rsp_rdata = 32'h0000_1234;
      end
      if (rsp_cnt > 0) begin
        rsp_cnt--;
        if (rsp_cnt == 0) begin
          rsp_valid = 1'b1;
          rsp_rdata = pend;
        end
      end
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      req_ready = rst_n && (lfsr[1:0] != 2'b00);
      if (req_valid && req_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 unexpected request", {31'b0, req_write, req_addr}, '0);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(req_write == e[64] && req_addr == e[63:32], t,
                {31'b0, req_write, req_addr}, {31'b0, e[64], e[63:32]});
          if (e[64]) check(req_wdata == e[31:0], t, {32'b0, req_wdata}, {32'b0, e[31:0]});
        end
        if (!req_write) begin
          bus = int'(req_addr[27:20]);
          if (bus >= 1 && bus <= MAX_BUS && kind[bus] != 2) begin
            rsp_cnt = 1 + int'(lfsr[2]) + 2 * int'(lfsr[3]);
            case (req_addr[11:0])
              12'h000: pend = (kind[bus] == 1) ? 32'hFFFF_FFFF : 32'h00A1_1AB2;
              12'h010: pend = bar_rb[bus];
              default: pend = {16'h0010, cmd_in[bus]};
            endcase
          end
        end
      end
    end
  end

  initial begin
    int waited;
    kind[1] = 0; bar_rb[1] = 32'hFF00_0000; cmd_in[1] = 16'h0100;
    kind[2] = 1; bar_rb[2] = 32'h0;         cmd_in[2] = 16'h0;
    kind[3] = 0; bar_rb[3] = 32'hFFFF_F00C; cmd_in[3] = 16'h0000;
    kind[4] = 0; bar_rb[4] = 32'hFE00_0000; cmd_in[4] = 16'h0002;
    kind[5] = 2; bar_rb[5] = 32'h0;         cmd_in[5] = 16'h0;
    kind[6] = 0; bar_rb[6] = 32'h0000_0000; cmd_in[6] = 16'h0400;
    build_expect();

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    // R1: quiet before link, spurious response ignored (R11)
    waited = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      spur_req = (i == 5);
      if (req_valid) waited++;
    end
    spur_req = 1'b0;
    check(waited == 0, "R1 no request before link", 64'(waited), 0);
    check(scan_done == 1'b0, "R1 done low after reset", 64'(scan_done), 0);
    check(dev_count == '0, "R1 count zero after reset", 64'(dev_count), 0);

    @(negedge clk);
    link_up = 1'b1;
    repeat (3) @(negedge clk);
    link_up = 1'b0;   // R10: drop after start, must be ignored

    waited = 0;
    while (!scan_done && waited < 20000) begin
      @(negedge clk);
      waited++;
    end
    check(scan_done == 1'b1, "R10 scan completes (watchdog)", 64'(scan_done), 1);

    if (scan_done) begin
      check(exp_q.size() == 0, "R3/R8 all expected requests seen", 64'(exp_q.size()), 0);
      check(int'(dev_count) == exp_count, "R9 device count", 64'(dev_count), 64'(exp_count));
      check(present_mask == exp_present, "R9 presence mask", 64'(present_mask), 64'(exp_present));
      check(present_mask[1] == 1'b0, "R3 absent bus not configured", 64'(present_mask[1]), 0);
      check(present_mask[4] == 1'b0, "R8 silent bus timed out", 64'(present_mask[4]), 0);
      for (int b = 1; b <= MAX_BUS; b++)
        check(base_flat[(b-1)*32 +: 32] == exp_base[b],
              (b == 6) ? "R6 zero window base" : "R5 assigned base",
              64'(base_flat[(b-1)*32 +: 32]), 64'(exp_base[b]));
      check(exp_base[4] == 32'h1200_0000, "R5 rounded-up base", 64'(exp_base[4]), 64'h1200_0000);
      link_up = 1'b1;
      repeat (10) @(negedge clk);
      check(scan_done == 1'b1 && int'(dev_count) == exp_count && !req_valid,
            "R10 results frozen after done", 64'(dev_count), 64'(exp_count));
    end else begin
      tests++;
      fails++;
      $display("FAIL R10 watchdog expired actual=%0d expected=done", waited);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule